// File: doc/BRIEF.md
# Supply and Pushbutton Reset Generator

This block turns two reset causes into one clean system reset. The first cause is a supply-good flag, already synchronous to the block clock, which an external comparator produces. The second is an active-low pushbutton input, taken straight from a mechanical switch. That input may bounce and has no timing relation to the clock. While either cause is present, the reset outputs stay asserted. Once both causes have cleared, the block keeps reset asserted for a further hold time, counted in clock cycles, and then releases it.

The pushbutton path first passes through a two-flop synchronizer. It then goes through a debouncer, which accepts a new level only after that level has been stable for DEBOUNCE_CYCLES consecutive clocks. The pushbutton input is treated as idle-high. Its synchronizer comes out of reset at the high level, so the block does not see an unpressed button as a press. If either cause returns during the hold time, the hold count starts again from zero. The block drives an active-low reset and its active-high complement.

Top module: `supply_reset_gen`

## Requirements
- R1: When `vcc_ok` is sampled low at a clock edge, `rst_n_o` is low after that edge and stays low for as long as `vcc_ok` stays low.
- R2: After `vcc_ok` returns high, with the button released, `rst_n_o` goes high after exactly HOLD_CYCLES clock edges that sample `vcc_ok` high.
- R3: A low level on `mr_raw_n` that is held steady pulls `rst_n_o` low after DEBOUNCE_CYCLES+3 clock edges: 2 for the synchronizer, DEBOUNCE_CYCLES for the debouncer and 1 for the output register.
- R4: When `mr_raw_n` goes back high and stays high, `rst_n_o` goes high after DEBOUNCE_CYCLES+HOLD_CYCLES+2 clock edges.
- R5: A low pulse on `mr_raw_n` that lasts fewer than DEBOUNCE_CYCLES clocks has no effect, and `rst_n_o` stays high.
- R6: While the button is pressed, bounces on `mr_raw_n` that are shorter than DEBOUNCE_CYCLES clocks do not start the release. The release timing of R4 counts from the last rising edge of `mr_raw_n`.
- R7: If either cause returns for even one clock during the hold time, the hold count is cleared. A full HOLD_CYCLES count is then needed after that cause clears.
- R8: `rst_o` is always the exact inverse of `rst_n_o`.
- R9: While `arst_n` is low, `rst_n_o` is low and `rst_o` is high, and the hold counter is cleared. After `arst_n` is released, with `vcc_ok` high and the button idle, reset releases after HOLD_CYCLES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| vcc_ok | input | 1 | Supply-good flag, synchronous to clk; high means the supply is good |
| mr_raw_n | input | 1 | Raw pushbutton reset, active low; idles high when undriven |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high, the inverse of rst_n_o |

## Verification
A fault in the hold counter shows up as a release edge on `rst_n_o` that comes one or more cycles early or late. The bench therefore samples that output one cycle before the expected release and again at the expected release. A debouncer that accepts a level too early passes short pulses and bounces through to the output. That shows up as a spurious low within DEBOUNCE_CYCLES+3 cycles of the glitch, or as a release that counts from the wrong rising edge. A hold counter that is not cleared during the hold time makes reset release within HOLD_CYCLES cycles of the restarting event.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
    typedef enum logic {
        PH_ACTIVE   = 1'b0,
        PH_RELEASED = 1'b1
    } rst_phase_t;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= {STAGES{IDLE_LVL}};
        else         chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
    parameter int DEBOUNCE_CYCLES = 16,
    parameter bit IDLE_LVL        = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic level
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] run;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din == st_q.level) begin
            st_d.run = '0;
        end else if (st_q.run == CW'(DEBOUNCE_CYCLES - 1)) begin
            st_d.level = din;
            st_d.run   = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{level: IDLE_LVL, run: '0};
        else         st_q <= st_d;
    end

    assign level = st_q.level;

    // R5: the accepted level moves only at the end of a full stable run
    a_r5_full_run: assert property (@(posedge clk) disable iff (!arst_n)
        !$stable(st_q.level) |->
            ($past(st_q.run) == CW'(DEBOUNCE_CYCLES - 1)) && ($past(din) != $past(st_q.level)));

    // R6: a run is never longer than the debounce window
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.run < CW'(DEBOUNCE_CYCLES));
endmodule

// File: rtl/rstgen_hold.sv
module rstgen_hold
    import rstgen_pkg::*;
#(
    parameter int HOLD_CYCLES = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic cause,
    output logic asserted
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        rst_phase_t    phase;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cause) begin
            st_d.phase = PH_ACTIVE;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_ACTIVE) begin
            if (st_q.cnt == CW'(HOLD_CYCLES - 1)) begin
                st_d.phase = PH_RELEASED;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{phase: PH_ACTIVE, cnt: '0};
        else         st_q <= st_d;
    end

    assign asserted = (st_q.phase == PH_ACTIVE);

    // R7: any cause clears the count and holds reset
    a_r7_restart: assert property (@(posedge clk) disable iff (!arst_n)
        cause |=> (st_q.cnt == '0) && (st_q.phase == PH_ACTIVE));

    // R2: release only after the last count value with no cause present
    a_r2_release_at_end: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(asserted) |-> ($past(st_q.cnt) == CW'(HOLD_CYCLES - 1)) && !$past(cause));

    // R2: counter stays idle once released
    a_r2_idle_when_released: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.phase == PH_RELEASED) |-> (st_q.cnt == '0));
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
    parameter int HOLD_CYCLES     = 1000,
    parameter int DEBOUNCE_CYCLES = 16,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic vcc_ok,
    input  logic mr_raw_n,
    output logic rst_n_o,
    output logic rst_o
);
    logic btn_sync_n;
    logic btn_level_n;
    logic any_cause;
    logic hold_active;

    rstgen_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
        .clk   (clk),
        .arst_n(arst_n),
        .din   (mr_raw_n),
        .dout  (btn_sync_n)
    );

    rstgen_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES), .IDLE_LVL(1'b1)) u_deb (
        .clk   (clk),
        .arst_n(arst_n),
        .din   (btn_sync_n),
        .level (btn_level_n)
    );

    assign any_cause = !vcc_ok || !btn_level_n;

    rstgen_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .arst_n  (arst_n),
        .cause   (any_cause),
        .asserted(hold_active)
    );

    assign rst_n_o = !hold_active;
    assign rst_o   = hold_active;

    // R1: a low supply flag forces reset on the following cycle
    a_r1_supply_low: assert property (@(posedge clk) disable iff (!arst_n)
        !vcc_ok |=> !rst_n_o);

    // R3: an accepted button press forces reset on the following cycle
    a_r3_button_low: assert property (@(posedge clk) disable iff (!arst_n)
        !btn_level_n |=> !rst_n_o);

    // R8: complementary outputs
    a_r8_complement: assert property (@(posedge clk) disable iff (!arst_n)
        rst_o == !rst_n_o);
endmodule

// File: tb/supply_reset_gen_test.sv
`timescale 1ns/1ps
module supply_reset_gen_test;
    localparam int HOLD = 20;
    localparam int DEB  = 6;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic vcc_ok = 1'b1;
    logic mr_raw_n = 1'b1;
    logic rst_n_o, rst_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supply_reset_gen #(.HOLD_CYCLES(HOLD), .DEBOUNCE_CYCLES(DEB), .SYNC_STAGES(2)) uut (
        .clk(clk), .arst_n(arst_n), .vcc_ok(vcc_ok), .mr_raw_n(mr_raw_n),
        .rst_n_o(rst_n_o), .rst_o(rst_o)
    );

    typedef struct packed {
        logic       vcc;
        logic       mr;
        logic [7:0] wait_n;
        logic       exp_n;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 8'd19, 1'b0},           // R9 not yet released
        '{1'b1, 1'b1, 8'd1,  1'b1},           // R9 released at HOLD
        '{1'b0, 1'b1, 8'd1,  1'b0},           // R1 immediate assert
        '{1'b0, 1'b1, 8'd30, 1'b0},           // R1 held
        '{1'b1, 1'b1, 8'd19, 1'b0},           // R2 one early
        '{1'b1, 1'b1, 8'd1,  1'b1},           // R2 release
        '{1'b1, 1'b0, 8'd8,  1'b1},           // R3 one early
        '{1'b1, 1'b0, 8'd1,  1'b0},           // R3 assert at DEB+3
        '{1'b1, 1'b0, 8'd40, 1'b0},           // R3 held
        '{1'b1, 1'b1, 8'd27, 1'b0},           // R4 one early
        '{1'b1, 1'b1, 8'd1,  1'b1}            // R4 release at DEB+HOLD+2
    };

    function automatic string vtag(int i);
        case (i)
            0, 1:    return "R9";
            2, 3:    return "R1";
            4, 5:    return "R2";
            6, 7, 8: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(string tag, logic exp_n);
        check(tag, rst_n_o, exp_n);
        check("R8", rst_o, ~exp_n);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        bit stayed_high;
        repeat (3) @(negedge clk);
        check_out("R9", 1'b0);
        arst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vcc_ok   = VECS[i].vcc;
            mr_raw_n = VECS[i].mr;
            edges(int'(VECS[i].wait_n));
            check_out(vtag(i), VECS[i].exp_n);
        end

        // R5: short button glitch ignored
        mr_raw_n = 1'b0;
        edges(2);
        mr_raw_n = 1'b1;
        stayed_high = 1'b1;
        for (int k = 0; k < 30; k++) begin
            edges(1);
            if (rst_n_o !== 1'b1) stayed_high = 1'b0;
        end
        check("R5", stayed_high, 1'b1);

        // R6: bouncing release counts from the last rise
        mr_raw_n = 1'b0;
        edges(40);
        check_out("R6", 1'b0);
        mr_raw_n = 1'b1; edges(2);
        mr_raw_n = 1'b0; edges(2);
        mr_raw_n = 1'b1; edges(3);
        mr_raw_n = 1'b0; edges(2);
        mr_raw_n = 1'b1;
        edges(DEB + HOLD + 1);
        check_out("R6", 1'b0);
        edges(1);
        check_out("R6", 1'b1);

        // R7: supply dip during hold restarts the count
        vcc_ok = 1'b0; edges(3);
        vcc_ok = 1'b1; edges(10);
        check_out("R7", 1'b0);
        vcc_ok = 1'b0; edges(1);
        vcc_ok = 1'b1;
        edges(HOLD - 1);
        check_out("R7", 1'b0);
        edges(1);
        check_out("R7", 1'b1);

        // R9: asynchronous reset mid-run asserts outputs at once
        #1 arst_n = 1'b0;
        #1 check_out("R9", 1'b0);
        @(negedge clk);
        arst_n = 1'b1;
        edges(HOLD - 1);
        check_out("R9", 1'b0);
        edges(1);
        check_out("R9", 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule